// File: doc/BRIEF.md
# Programmable CPU Clock Generator with Slow-Cycle Stretching

This block produces the processor clock from a fast reference clock. In normal operation the clock is a divided copy of the reference. A five-bit reload value N, held in a write-only clock register, sets the period to N+1 reference cycles. When the address decoder marks an access as slow, or a force-slow control bit is set, the block ends the current fast cycle. It then holds the processor clock low until the slower host bus clock (PHI2) rises, and keeps it high for exactly as long as PHI2 stays high. Fast clocking restarts once PHI2 falls again.

The point where a slow request is taken depends on a mode bit in the clock register. A request is accepted only at a fast-cycle boundary, and only after a minimum number of fast clock edges has passed since the last PHI2 fall. Early sampling needs one edge and suits a 2 MHz host bus. Late sampling needs three edges and lets a bus-idle CPU cycle finish inside PHI1 on a 1 MHz bus. PHI2 is brought into the reference domain through a synchronizer, so all slow-cycle timing runs on the synchronized copy.

Top module: `cpu_clock_gen`

## Requirements
- R1: After reset the processor clock and the slow flag are low, the reload value is 15 and the sampling mode is early. The first fast cycles are therefore 8 reference cycles low and 8 high.
- R2: Writing the clock register takes the reload value N from data bits 4..0 and the sampling mode from bit 7 (1 = early, 0 = late). Bits 6..5 have no effect. Each fast cycle is floor(N/2)+1 reference cycles low, followed by N-floor(N/2) reference cycles high.
- R3: A reload value of 0 behaves as 1, giving one reference cycle low and one high.
- R4: A reload value written in the middle of a cycle takes effect only at the next cycle boundary. The running cycle keeps its old high time, and the following cycle uses the new timing.
- R5: A slow cycle starts only at a fast-cycle boundary where the clock falls. The clock then stays low until synchronized PHI2 rises and stays high for exactly the PHI2 high time. The slow flag is high throughout the slow cycle.
- R6: When PHI2 falls at the end of a slow cycle, fast clocking restarts with a full low phase of the current timing.
- R7: In early mode, with slow requests held active, each PHI2 period holds one fast cycle followed by one slow cycle, provided the reload value is 15 and PHI2 is 50 reference cycles high and 50 low.
- R8: In late mode, under the same conditions, each PHI2 period holds two fast cycles followed by one slow cycle.
- R9: With the force-slow input high, slow cycles occur even when the decoder request is low.
- R10: With both request inputs low, no slow cycle occurs and the clock keeps its fast period through PHI2 edges.
- R11: A slow cycle never starts at a boundary that falls after a PHI2 rise, or before the first PHI2 fall after reset, and before that point the slow flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock (50 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| phi2 | input | 1 | Host bus clock, asynchronous to clk_ref |
| slow_req | input | 1 | Decoder marks the coming access as slow |
| force_slow | input | 1 | Control bit: every access is slow |
| reg_we | input | 1 | Write strobe for the clock register |
| reg_wdata | input | 8 | Clock register write data |
| cpu_clk | output | 1 | Generated processor clock |
| slow_active | output | 1 | High while a slow cycle is in progress |

## Verification
Fast timing is first measured pulse by pulse for a set of reload values. The set includes an odd and an even divisor, the smallest one, the zero value that is raised to the minimum, and the largest one, so that rounding of the low and high halves can be told apart. The bench then runs PHI2 at a fixed rate and counts processor clock rises per PHI2 period. This count gives different values for early mode, late mode and no requests, and it separates the decoder request from the force-slow path. Directed cases cover a reload written in the middle of a cycle, the length of a slow high pulse and of the low phase after it, and the absence of slow cycles before PHI2 has ever fallen.

// File: rtl/cpu_clock_gen.sv
module cpu_clock_gen #(
  parameter int                 LATCH_W     = 5,
  parameter logic [LATCH_W-1:0] LATCH_RST   = 15,
  parameter int                 SYNC_LEN    = 2,
  parameter int                 EARLY_EDGES = 1,
  parameter int                 LATE_EDGES  = 3
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       phi2,
  input  logic       slow_req,
  input  logic       force_slow,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic       cpu_clk,
  output logic       slow_active
);
  localparam int EDGE_W = $clog2(LATE_EDGES + 1);
  localparam logic [EDGE_W-1:0] EDGE_MAX = EDGE_W'(LATE_EDGES);
  localparam logic [LATCH_W-1:0] ONE = LATCH_W'(1);

  typedef enum logic [1:0] {ST_FAST, ST_SLOW_LO, ST_SLOW_HI} state_t;

  state_t              state;
  logic [LATCH_W-1:0]  latch_q, div_q, cnt;
  logic                fastmode;
  logic [SYNC_LEN-1:0] sync_q;
  logic                phi2_s, phi2_d, armed;
  logic [EDGE_W-1:0]   edges;

  assign phi2_s = sync_q[SYNC_LEN-1];

  wire phi2_fall = phi2_d & ~phi2_s;
  wire phi2_rise = ~phi2_d & phi2_s;
  wire [LATCH_W-1:0] half = div_q >> 1;
  wire [LATCH_W-1:0] eff  = (latch_q == '0) ? ONE : latch_q;
  wire is_fast  = (state == ST_FAST);
  wire rise_evt = is_fast && (cnt == half);
  wire fall_evt = is_fast && (cnt == div_q);
  wire fast_hi  = cnt > half;
  wire [31:0] need = fastmode ? EARLY_EDGES : LATE_EDGES;
  wire edges_ok = (32'(edges) + 32'd1) >= need;
  wire take_slow = fall_evt && armed && edges_ok && (slow_req || force_slow);

  assign cpu_clk     = is_fast ? fast_hi : (state == ST_SLOW_HI);
  assign slow_active = !is_fast;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= LATCH_RST;
      fastmode <= 1'b1;
    end else if (reg_we) begin
      latch_q  <= reg_wdata[LATCH_W-1:0];
      fastmode <= reg_wdata[7];
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      phi2_d <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], phi2};
      phi2_d <= phi2_s;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      edges <= '0;
    end else if (phi2_fall) begin
      armed <= 1'b1;
      edges <= '0;
    end else if (phi2_rise) begin
      armed <= 1'b0;
      edges <= '0;
    end else if (armed && (rise_evt || fall_evt) && edges != EDGE_MAX) begin
      edges <= edges + 1'b1;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FAST;
      cnt   <= '0;
      div_q <= (LATCH_RST == '0) ? ONE : LATCH_RST;
    end else begin
      case (state)
        ST_FAST: begin
          if (fall_evt) begin
            cnt   <= '0;
            div_q <= eff;
            if (take_slow) state <= ST_SLOW_LO;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SLOW_LO: if (phi2_s) state <= ST_SLOW_HI;
        ST_SLOW_HI: begin
          if (!phi2_s) begin
            state <= ST_FAST;
            cnt   <= '0;
            div_q <= eff;
          end
        end
        default: state <= ST_FAST;
      endcase
    end
  end
endmodule

// File: rtl/cpu_clock_gen_chk.sv
module cpu_clock_gen_chk #(
  parameter int LATCH_W = 5
) (
  input logic               clk_ref,
  input logic               rst_n,
  input logic               cpu_clk,
  input logic               slow_active,
  input logic               slow_req,
  input logic               force_slow,
  input logic               phi2_s,
  input logic               armed,
  input logic [LATCH_W-1:0] cnt,
  input logic [LATCH_W-1:0] div_q
);
  assert_enter_on_fall_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(slow_active) |-> $fell(cpu_clk));

  assert_held_low_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (slow_active && $past(slow_active) && !$past(phi2_s)) |-> !cpu_clk);

  assert_entry_requested_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(slow_active) |-> $past(slow_req || force_slow));

  assert_entry_armed_R11: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(slow_active) |-> $past(armed));

  assert_count_range_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cnt <= div_q);

  assert_div_nonzero_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    div_q != '0);
endmodule

bind cpu_clock_gen cpu_clock_gen_chk #(.LATCH_W(LATCH_W)) u_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .cpu_clk    (cpu_clk),
  .slow_active(slow_active),
  .slow_req   (slow_req),
  .force_slow (force_slow),
  .phi2_s     (phi2_s),
  .armed      (armed),
  .cnt        (cnt),
  .div_q      (div_q)
);

// File: tb/tb_cpu_clock_gen.sv
module tb_cpu_clock_gen;
  localparam int CLK_PERIOD = 20;
  localparam int PHI2_HALF  = 1000;
  localparam int NVEC = 7;
  localparam logic [7:0] VW [NVEC] = '{8'h8F, 8'hE9, 8'h85, 8'h84, 8'h81, 8'h80, 8'h9F};
  localparam int         VH [NVEC] = '{8, 5, 3, 2, 1, 1, 16};
  localparam int         VL [NVEC] = '{8, 5, 3, 3, 1, 1, 16};

  logic clk_ref = 1'b0, rst_n = 1'b0, phi2 = 1'b0, phi2_run = 1'b0;
  logic slow_req = 1'b0, force_slow = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic cpu_clk, slow_active;

  int checks = 0, errors = 0, cyc = 0, rises = 0;
  logic cpu_prev = 1'b0, slow_seen = 1'b0;

  cpu_clock_gen dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .phi2(phi2), .slow_req(slow_req),
    .force_slow(force_slow), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .cpu_clk(cpu_clk), .slow_active(slow_active)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  always begin
    #(PHI2_HALF);
    if (phi2_run) phi2 = ~phi2;
    else phi2 = 1'b0;
  end

  always @(negedge clk_ref) begin
    if (cpu_clk && !cpu_prev) rises++;
    cpu_prev = cpu_clk;
    if (slow_active) slow_seen = 1'b1;
  end

  always @(posedge clk_ref) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_ref);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk_ref);
    reg_we = 1'b0;
  endtask

  task automatic meas(output int hi, output int lo);
    @(negedge clk_ref);
    while (cpu_clk) @(negedge clk_ref);
    while (!cpu_clk) @(negedge clk_ref);
    hi = 0;
    while (cpu_clk) begin hi++; @(negedge clk_ref); end
    lo = 0;
    while (!cpu_clk) begin lo++; @(negedge clk_ref); end
  endtask

  task automatic count_rises(output int n);
    int r0;
    repeat (2) @(negedge phi2);
    r0 = rises;
    repeat (4) @(negedge phi2);
    n = rises - r0;
  endtask

  initial begin
    int hi, lo, n;
    repeat (3) @(negedge clk_ref);
    chk("R1 clock low in reset", cpu_clk, 0);
    chk("R1 slow flag low in reset", slow_active, 0);
    rst_n = 1'b1;
    meas(hi, lo);
    chk("R1 default high time", hi, 8);
    chk("R1 default low time", lo, 8);

    force_slow = 1'b1;
    slow_seen = 1'b0;
    repeat (100) @(negedge clk_ref);
    chk("R11 no slow cycle before first PHI2 fall", slow_seen, 0);
    force_slow = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      wr(VW[i]);
      meas(hi, lo);
      meas(hi, lo);
      chk(VW[i][4:0] == 0 ? "R3 zero reload high" : "R2 high time", hi, VH[i]);
      chk(VW[i][4:0] == 0 ? "R3 zero reload low" : "R2 low time", lo, VL[i]);
    end

    wr(8'h8F);
    meas(hi, lo);
    @(negedge clk_ref);
    while (!(cpu_clk && !cpu_prev)) @(negedge clk_ref);
    reg_we = 1'b1; reg_wdata = 8'h9F;
    hi = 1;
    @(negedge clk_ref);
    reg_we = 1'b0;
    while (cpu_clk) begin hi++; @(negedge clk_ref); end
    lo = 0;
    while (!cpu_clk) begin lo++; @(negedge clk_ref); end
    chk("R4 running cycle keeps old high time", hi, 8);
    chk("R4 next cycle uses new low time", lo, 16);

    wr(8'h8F);
    phi2_run = 1'b1;
    force_slow = 1'b1;
    repeat (3) @(negedge phi2);
    @(negedge phi2);
    repeat (30) @(negedge clk_ref);
    chk("R5 slow flag during wait", slow_active, 1);
    chk("R5 clock held low until PHI2 rises", cpu_clk, 0);
    @(posedge phi2);
    meas(hi, lo);
    chk("R5 slow high equals PHI2 high", hi, 50);
    chk("R6 full low phase after PHI2 fall", lo, 8);

    count_rises(n);
    chk("R9 force-slow early mode rises in 4 periods", n, 8);
    wr(8'h6F);
    count_rises(n);
    chk("R8 late mode rises in 4 periods", n, 12);
    force_slow = 1'b0;
    slow_req = 1'b1;
    count_rises(n);
    chk("R8 decoder request late mode rises", n, 12);
    wr(8'h8F);
    count_rises(n);
    chk("R7 decoder request early mode rises", n, 8);

    slow_req = 1'b0;
    repeat (2) @(negedge phi2);
    slow_seen = 1'b0;
    count_rises(n);
    chk("R10 fast-only rises in 4 periods", n, 25);
    chk("R10 no slow flag without requests", slow_seen, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule